// File: doc/BRIEF.md
# Plane-View Frame Buffer Bridge

This block lets an 8-bit requester treat a packed frame buffer as if it were split into bit planes. The frame buffer holds 4-bit pixels, eight to a 32-bit word. Each byte of a 32 KB window stands for one such word. A window read fetches the word and collects one chosen plane bit from each of its eight pixels into a byte. A window write turns each data bit into a plane pattern for its pixel. It fetches the word, replaces only the planes that are enabled and stores the word back.

Two small byte registers hold the state that shapes these accesses. The plane register selects the plane for reads and the plane mask for writes. The bank register moves all frame-buffer traffic to a second region. A CPU port reaches both the registers and the window. A DMA port reaches the window only, with the same read and write results. Both ports share one 32-bit memory port that uses a request/acknowledge handshake. Only one access is in flight at a time, and the requester that is not being served sees its ready signal held low.

Top module: `vram_plane_bridge`

## Requirements
- R1: After reset, a read of the plane register (CPU register access, address bit 0 = 0) returns 0x0F and a read of the bank register (address bit 0 = 1) returns 0xE7.
- R2: A write to the plane register stores data bits 7:6 as the read-plane index and bits 3:0 as the write-plane mask. Reading it back returns the index in bits 7:6, the mask in bits 3:0 and zeros in bits 5:4.
- R3: A write to the bank register stores data bit 4 as the bank flag. Reading it back returns 0xF7 when the flag is set and 0xE7 when it is clear.
- R4: A window access at window address A uses the memory byte address A*4, plus 0x20000 when the bank flag is set.
- R5: A window read returns a byte in which bit 7-p equals bit k of pixel p, where k is the read-plane index. Pixel p sits in memory byte p/2 (byte 0 = word bits 7:0), in the high nibble for even p and in the low nibble for odd p.
- R6: A window write with data D and mask M replaces pixel p (same placement as R5) with (old & ~M) | (D[7-p] ? M : 0). All other bits of the word are kept, so a mask of 0 leaves the word unchanged.
- R7: A window write issues a memory read and then a memory write to the same address. The requester sees ready only after the memory write has been acknowledged.
- R8: A window access through the DMA port produces the same read byte and the same stored word as the same access through the CPU port.
- R9: When both ports request in the same idle cycle, the DMA access is served first. The CPU ready stays low until the DMA access is done, and the two ready signals are never high together.
- R10: Once the memory request is raised, it stays high with a stable address and direction until it is acknowledged.
- R11: A register access makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ready |
| cpu_reg | input | 1 | 1 = register access, 0 = window access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Window address; bit 0 selects the register on register accesses |
| cpu_wdata | input | 8 | CPU write data |
| cpu_ready | output | 1 | One-cycle completion pulse for the CPU |
| dma_req | input | 1 | DMA window request, held until dma_ready |
| dma_we | input | 1 | 1 = write, 0 = read |
| dma_addr | input | 15 | DMA window address |
| dma_wdata | input | 8 | DMA write data |
| dma_ready | output | 1 | One-cycle completion pulse for DMA |
| rd_data | output | 8 | Read result, valid with the ready pulse |
| vm_req | output | 1 | Memory request |
| vm_we | output | 1 | Memory direction, 1 = write |
| vm_addr | output | 18 | Memory byte address |
| vm_wdata | output | 32 | Memory write word |
| vm_rdata | input | 32 | Memory read word, valid with vm_ack |
| vm_ack | input | 1 | Memory acknowledge |

## Verification
A DMA write and a CPU write can both present requests in the same idle cycle, and both may target one word. The bench starts both requests on the same clock edge, each writing a different half of the same word's pixels through the same plane. The final word shows which write landed last, so it exposes the order of service. The bench also compares when each ready pulse came back. A CPU-first design leaves a different word in memory and returns the CPU ready first.

// File: rtl/vpb_pkg.sv
package vpb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_STORE,
      ST_DONE
   } vpb_state_e;

   // Register layout shared by the register file and its readback
   localparam int IDX_LSB   = 6;
   localparam int BANK_BIT  = 4;
   localparam logic [7:0] BANK_RD_FILL = 8'hE7;

   // Bit position of the least significant bit of pixel p inside a word.
   // ppb: pixels per byte; high_first: first pixel of a byte in the upper slot
   function automatic int pix_lsb(input int p, input int pix_w,
                                  input int ppb, input bit high_first);
      int byte_i;
      int slot;
      byte_i = p / ppb;
      slot   = p % ppb;
      if (high_first) slot = ppb - 1 - slot;
      return byte_i * 8 + slot * pix_w;
   endfunction

endpackage

// File: rtl/vpb_regs.sv
module vpb_regs #(
   parameter int DATA_W = 8,
   parameter int PIX_W  = 4,
   localparam int IDX_W = $clog2(PIX_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [PIX_W-1:0]  wr_mask,
   output logic              bank_on,
   output logic [DATA_W-1:0] rdback
);
   import vpb_pkg::*;

   generate
      if (DATA_W != 8 || PIX_W != 4) begin : g_bad_layout
         $error("vpb_regs: register layout needs DATA_W=8 and PIX_W=4");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_idx  <= '0;
         wr_mask <= '1;
         bank_on <= 1'b0;
      end else if (wr_en) begin
         if (sel) begin
            bank_on <= wdata[BANK_BIT];
         end else begin
            rd_idx  <= wdata[IDX_LSB +: IDX_W];
            wr_mask <= wdata[PIX_W-1:0];
         end
      end
   end

   always_comb begin
      rdback = '0;
      if (sel) begin
         rdback = BANK_RD_FILL;
         rdback[BANK_BIT] = bank_on;
      end else begin
         rdback[IDX_LSB +: IDX_W] = rd_idx;
         rdback[PIX_W-1:0]        = wr_mask;
      end
   end

endmodule

// File: rtl/vpb_gather.sv
module vpb_gather #(
   parameter int  WORD_W     = 32,
   parameter int  PIX_W      = 4,
   parameter bit  HIGH_FIRST = 1'b1,
   localparam int NPIX  = WORD_W / PIX_W,
   localparam int PPB   = 8 / PIX_W,
   localparam int IDX_W = $clog2(PIX_W)
) (
   input  logic [WORD_W-1:0] word,
   input  logic [IDX_W-1:0]  plane,
   output logic [NPIX-1:0]   bits
);
   import vpb_pkg::*;

   generate
      if ((WORD_W % 8) != 0 || (8 % PIX_W) != 0) begin : g_bad_geom
         $error("vpb_gather: pixels must tile bytes and bytes must tile the word");
      end
      for (genvar p = 0; p < NPIX; p++) begin : g_pix
         localparam int LSB = pix_lsb(p, PIX_W, PPB, HIGH_FIRST);
         logic [PIX_W-1:0] nib;
         assign nib = word[LSB +: PIX_W];
         assign bits[NPIX-1-p] = nib[plane];
      end
   endgenerate

endmodule

// File: rtl/vpb_merge.sv
module vpb_merge #(
   parameter int  WORD_W     = 32,
   parameter int  PIX_W      = 4,
   parameter bit  HIGH_FIRST = 1'b1,
   localparam int NPIX = WORD_W / PIX_W,
   localparam int PPB  = 8 / PIX_W
) (
   input  logic [WORD_W-1:0] old_word,
   input  logic [NPIX-1:0]   data,
   input  logic [PIX_W-1:0]  mask,
   output logic [WORD_W-1:0] new_word
);
   import vpb_pkg::*;

   generate
      if (NPIX * PIX_W != WORD_W) begin : g_bad_fill
         $error("vpb_merge: pixels must cover the whole word");
      end
      for (genvar p = 0; p < NPIX; p++) begin : g_pix
         localparam int LSB = pix_lsb(p, PIX_W, PPB, HIGH_FIRST);
         logic [PIX_W-1:0] keep;
         logic [PIX_W-1:0] put;
         assign keep = old_word[LSB +: PIX_W] & ~mask;
         assign put  = {PIX_W{data[NPIX-1-p]}} & mask;
         assign new_word[LSB +: PIX_W] = keep | put;
      end
   endgenerate

endmodule

// File: rtl/vpb_ctrl.sv
module vpb_ctrl #(
   parameter int DATA_W      = 8,
   parameter int WORD_W      = 32,
   parameter int WIN_AW      = 15,
   parameter int VADDR_W     = 18,
   parameter int BANK_OFFSET = 32'h20000,
   localparam int BYTE_SH    = $clog2(WORD_W / 8)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_reg,
   input  logic               cpu_we,
   input  logic [WIN_AW-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic               cpu_ready,
   input  logic               dma_req,
   input  logic               dma_we,
   input  logic [WIN_AW-1:0]  dma_addr,
   input  logic [DATA_W-1:0]  dma_wdata,
   output logic               dma_ready,
   output logic [DATA_W-1:0]  rd_data,
   output logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_rdback,
   input  logic               bank_on,
   output logic [DATA_W-1:0]  op_data,
   input  logic [DATA_W-1:0]  gathered,
   input  logic [WORD_W-1:0]  merged,
   output logic               vm_req,
   output logic               vm_we,
   output logic [VADDR_W-1:0] vm_addr,
   output logic [WORD_W-1:0]  vm_wdata,
   input  logic               vm_ack
);
   import vpb_pkg::*;

   localparam logic [VADDR_W-1:0] BANK_OFF_V = VADDR_W'(BANK_OFFSET);

   generate
      if (WIN_AW + BYTE_SH >= VADDR_W) begin : g_bad_aw
         $error("vpb_ctrl: memory address too narrow for the window");
      end
      if (BANK_OFFSET + (2 ** (WIN_AW + BYTE_SH)) > (2 ** VADDR_W)) begin : g_bad_bank
         $error("vpb_ctrl: banked window exceeds the memory address range");
      end
   endgenerate

   vpb_state_e          state;
   logic                owner_dma;
   logic                op_we;
   logic [VADDR_W-1:0]  addr_q;
   logic [WORD_W-1:0]   store_q;
   logic [DATA_W-1:0]   rd_q;
   logic                take_dma;
   logic                take_cpu;
   logic [WIN_AW-1:0]   win_sel;

   assign take_dma = (state == ST_IDLE) && dma_req;
   assign take_cpu = (state == ST_IDLE) && !dma_req && cpu_req;
   assign win_sel  = take_dma ? dma_addr : cpu_addr;

   function automatic logic [VADDR_W-1:0] map_addr(input logic [WIN_AW-1:0] a,
                                                    input logic bank);
      logic [VADDR_W-1:0] base;
      base = VADDR_W'({a, {BYTE_SH{1'b0}}});
      return base + (bank ? BANK_OFF_V : '0);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         owner_dma <= 1'b0;
         op_we     <= 1'b0;
         op_data   <= '0;
         addr_q    <= '0;
         store_q   <= '0;
         rd_q      <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (take_dma) begin
                  owner_dma <= 1'b1;
                  op_we     <= dma_we;
                  op_data   <= dma_wdata;
                  addr_q    <= map_addr(win_sel, bank_on);
                  state     <= ST_FETCH;
               end else if (take_cpu) begin
                  owner_dma <= 1'b0;
                  op_we     <= cpu_we;
                  op_data   <= cpu_wdata;
                  if (cpu_reg) begin
                     if (!cpu_we) rd_q <= reg_rdback;
                     state <= ST_DONE;
                  end else begin
                     addr_q <= map_addr(win_sel, bank_on);
                     state  <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (vm_ack) begin
                  if (op_we) begin
                     store_q <= merged;
                     state   <= ST_STORE;
                  end else begin
                     rd_q  <= gathered;
                     state <= ST_DONE;
                  end
               end
            end
            ST_STORE: begin
               if (vm_ack) state <= ST_DONE;
            end
            ST_DONE: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign reg_wr    = take_cpu && cpu_reg && cpu_we;
   assign vm_req    = (state == ST_FETCH) || (state == ST_STORE);
   assign vm_we     = (state == ST_STORE);
   assign vm_addr   = addr_q;
   assign vm_wdata  = store_q;
   assign cpu_ready = (state == ST_DONE) && !owner_dma;
   assign dma_ready = (state == ST_DONE) && owner_dma;
   assign rd_data   = rd_q;

endmodule

// File: rtl/vram_plane_bridge.sv
module vram_plane_bridge #(
   parameter int DATA_W      = 8,
   parameter int WORD_W      = 32,
   parameter int PIX_W       = 4,
   parameter int WIN_AW      = 15,
   parameter int VADDR_W     = 18,
   parameter int BANK_OFFSET = 32'h20000,
   parameter bit HIGH_FIRST  = 1'b1,
   localparam int NPIX  = WORD_W / PIX_W,
   localparam int IDX_W = $clog2(PIX_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_reg,
   input  logic               cpu_we,
   input  logic [WIN_AW-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic               cpu_ready,
   input  logic               dma_req,
   input  logic               dma_we,
   input  logic [WIN_AW-1:0]  dma_addr,
   input  logic [DATA_W-1:0]  dma_wdata,
   output logic               dma_ready,
   output logic [DATA_W-1:0]  rd_data,
   output logic               vm_req,
   output logic               vm_we,
   output logic [VADDR_W-1:0] vm_addr,
   output logic [WORD_W-1:0]  vm_wdata,
   input  logic [WORD_W-1:0]  vm_rdata,
   input  logic               vm_ack
);

   generate
      if (NPIX != DATA_W) begin : g_bad_width
         $error("vram_plane_bridge: one data bit per pixel of a word is required");
      end
   endgenerate

   logic               reg_wr;
   logic [DATA_W-1:0]  reg_rdback;
   logic [IDX_W-1:0]   rd_idx;
   logic [PIX_W-1:0]   wr_mask;
   logic               bank_on;
   logic [DATA_W-1:0]  op_data;
   logic [NPIX-1:0]    gathered;
   logic [WORD_W-1:0]  merged;

   vpb_regs #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .sel     (cpu_addr[0]),
      .wdata   (cpu_wdata),
      .rd_idx  (rd_idx),
      .wr_mask (wr_mask),
      .bank_on (bank_on),
      .rdback  (reg_rdback)
   );

   vpb_gather #(.WORD_W(WORD_W), .PIX_W(PIX_W), .HIGH_FIRST(HIGH_FIRST)) u_gather (
      .word  (vm_rdata),
      .plane (rd_idx),
      .bits  (gathered)
   );

   vpb_merge #(.WORD_W(WORD_W), .PIX_W(PIX_W), .HIGH_FIRST(HIGH_FIRST)) u_merge (
      .old_word (vm_rdata),
      .data     (op_data),
      .mask     (wr_mask),
      .new_word (merged)
   );

   vpb_ctrl #(
      .DATA_W(DATA_W), .WORD_W(WORD_W), .WIN_AW(WIN_AW),
      .VADDR_W(VADDR_W), .BANK_OFFSET(BANK_OFFSET)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_req    (cpu_req),
      .cpu_reg    (cpu_reg),
      .cpu_we     (cpu_we),
      .cpu_addr   (cpu_addr),
      .cpu_wdata  (cpu_wdata),
      .cpu_ready  (cpu_ready),
      .dma_req    (dma_req),
      .dma_we     (dma_we),
      .dma_addr   (dma_addr),
      .dma_wdata  (dma_wdata),
      .dma_ready  (dma_ready),
      .rd_data    (rd_data),
      .reg_wr     (reg_wr),
      .reg_rdback (reg_rdback),
      .bank_on    (bank_on),
      .op_data    (op_data),
      .gathered   (gathered),
      .merged     (merged),
      .vm_req     (vm_req),
      .vm_we      (vm_we),
      .vm_addr    (vm_addr),
      .vm_wdata   (vm_wdata),
      .vm_ack     (vm_ack)
   );

endmodule

// File: rtl/vpb_checker.sv
module vpb_checker #(
   parameter int VADDR_W = 18
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_ready,
   input logic               dma_ready,
   input logic               vm_req,
   input logic               vm_we,
   input logic [VADDR_W-1:0] vm_addr,
   input logic               vm_ack
);

   p_ready_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_ready && dma_ready));

   p_cpu_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (vm_req && !vm_ack) |=> (vm_req && $stable(vm_addr) && $stable(vm_we)));

   p_store_follows_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vm_req && vm_we && !$past(vm_req && vm_we)) |-> $past(vm_req && !vm_we && vm_ack));

   p_store_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vm_req && vm_we && !$past(vm_req && vm_we)) |-> (vm_addr == $past(vm_addr)));

   p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vm_req |-> (vm_addr[1:0] == 2'b00));

   p_ready_after_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vm_req && vm_we && vm_ack) |=> (cpu_ready || dma_ready));

endmodule

bind vram_plane_bridge vpb_checker #(.VADDR_W(VADDR_W)) u_vpb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_ready (cpu_ready),
   .dma_ready (dma_ready),
   .vm_req    (vm_req),
   .vm_we     (vm_we),
   .vm_addr   (vm_addr),
   .vm_ack    (vm_ack)
);

// File: tb/vram_plane_bridge_tb_top.sv
module vram_plane_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_reg = 1'b0, cpu_we = 1'b0;
   logic [14:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_ready;
   logic        dma_req = 1'b0, dma_we = 1'b0;
   logic [14:0] dma_addr = '0;
   logic [7:0]  dma_wdata = '0;
   logic        dma_ready;
   logic [7:0]  rd_data;
   logic        vm_req, vm_we;
   logic [17:0] vm_addr;
   logic [31:0] vm_wdata;
   logic [31:0] vm_rdata = '0;
   logic        vm_ack = 1'b0;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   vram_plane_bridge dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_reg(cpu_reg), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
      .dma_wdata(dma_wdata), .dma_ready(dma_ready), .rd_data(rd_data),
      .vm_req(vm_req), .vm_we(vm_we), .vm_addr(vm_addr), .vm_wdata(vm_wdata),
      .vm_rdata(vm_rdata), .vm_ack(vm_ack)
   );

   // Memory model: 32 words, index = {bank bit, word address bits 3:0}
   logic [31:0] mem [32];
   int          lat = 0;
   int          cnt = 0;
   int          acc_cnt = 0;
   int          wr_cnt = 0;
   logic [17:0] last_addr = '0;

   function automatic int midx(input logic [17:0] a);
      return int'({a[17], a[5:2]});
   endfunction

   always @(posedge clk) begin
      vm_ack <= 1'b0;
      if (vm_req && !vm_ack) begin
         if (cnt >= lat) begin
            cnt       <= 0;
            vm_ack    <= 1'b1;
            last_addr <= vm_addr;
            acc_cnt   <= acc_cnt + 1;
            if (vm_we) begin
               mem[midx(vm_addr)] <= vm_wdata;
               wr_cnt <= wr_cnt + 1;
            end else begin
               vm_rdata <= mem[midx(vm_addr)];
            end
         end else begin
            cnt <= cnt + 1;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cpu_xfer(input logic isreg, input logic we, input logic [14:0] a,
                           input logic [7:0] wd, output logic [7:0] rd, output time t);
      cpu_reg = isreg; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
      forever begin
         @(negedge clk);
         if (cpu_ready) break;
      end
      rd = rd_data; t = $time; cpu_req = 1'b0;
   endtask

   task automatic dma_xfer(input logic we, input logic [14:0] a, input logic [7:0] wd,
                           output logic [7:0] rd, output time t);
      dma_we = we; dma_addr = a; dma_wdata = wd; dma_req = 1'b1;
      forever begin
         @(negedge clk);
         if (dma_ready) break;
      end
      rd = rd_data; t = $time; dma_req = 1'b0;
   endtask

   // {init word, read plane, write mask, write data, expected read byte, expected word}
   localparam logic [85:0] VEC [4] = '{
      {32'h00000000, 2'd0, 4'hF, 8'hFF, 8'h00, 32'hFFFFFFFF},
      {32'h12345678, 2'd0, 4'h1, 8'h00, 8'hAA, 32'h02244668},
      {32'h12345678, 2'd3, 4'hA, 8'hC3, 8'h40, 32'hBA1454FA},
      {32'hA5C3F00F, 2'd2, 4'h4, 8'h5A, 8'h69, 32'hE1C3B40F}
   };

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R7 actual=hung expected=completed (watchdog)");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] rd;
      time        t_cpu, t_dma;
      int         acc0;
      for (int i = 0; i < 32; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      cpu_xfer(1'b1, 1'b0, 15'd0, 8'h00, rd, t_cpu);
      check("R1 plane reset", {24'h0, rd}, 32'h0F);
      cpu_xfer(1'b1, 1'b0, 15'd1, 8'h00, rd, t_cpu);
      check("R1 bank reset", {24'h0, rd}, 32'hE7);

      // R11: register accesses make no memory request
      acc0 = acc_cnt;
      cpu_xfer(1'b1, 1'b1, 15'd0, 8'hF5, rd, t_cpu);
      cpu_xfer(1'b1, 1'b0, 15'd0, 8'h00, rd, t_cpu);
      // R2: bits 5:4 not stored
      check("R2 plane readback", {24'h0, rd}, 32'hC5);
      check("R11 no memory traffic", acc_cnt, acc0);

      // R3: bank flag readback
      cpu_xfer(1'b1, 1'b1, 15'd1, 8'h10, rd, t_cpu);
      cpu_xfer(1'b1, 1'b0, 15'd1, 8'h00, rd, t_cpu);
      check("R3 bank set readback", {24'h0, rd}, 32'hF7);
      cpu_xfer(1'b1, 1'b1, 15'd1, 8'hEF, rd, t_cpu);
      cpu_xfer(1'b1, 1'b0, 15'd1, 8'h00, rd, t_cpu);
      check("R3 bank clear readback", {24'h0, rd}, 32'hE7);

      // Vector table: R5 read gather, R6 write merge, R7 sequence
      for (int i = 0; i < 4; i++) begin
         int w0;
         lat = (i % 2) * 2;
         mem[i + 1] = VEC[i][85:54];
         cpu_xfer(1'b1, 1'b1, 15'd0, {VEC[i][53:52], 2'b00, VEC[i][51:48]}, rd, t_cpu);
         cpu_xfer(1'b0, 1'b0, 15'(i + 1), 8'h00, rd, t_cpu);
         check($sformatf("R5 gather vec%0d", i), {24'h0, rd}, {24'h0, VEC[i][39:32]});
         w0 = wr_cnt;
         cpu_xfer(1'b0, 1'b1, 15'(i + 1), VEC[i][47:40], rd, t_cpu);
         check($sformatf("R6 merge vec%0d", i), mem[i + 1], VEC[i][31:0]);
         check($sformatf("R7 one store vec%0d", i), wr_cnt - w0, 1);
      end

      // R8: DMA read and write match CPU results (plane 0, mask 1)
      lat = 1;
      cpu_xfer(1'b1, 1'b1, 15'd0, 8'h01, rd, t_cpu);
      mem[6] = 32'h12345678;
      dma_xfer(1'b0, 15'd6, 8'h00, rd, t_dma);
      check("R8 dma gather", {24'h0, rd}, 32'hAA);
      dma_xfer(1'b1, 15'd6, 8'h00, rd, t_dma);
      check("R8 dma merge", mem[6], 32'h02244668);

      // R6: mask 0 write keeps the word; R7 still stores
      cpu_xfer(1'b1, 1'b1, 15'd0, 8'h00, rd, t_cpu);
      mem[7] = 32'h12345678;
      acc0 = wr_cnt;
      cpu_xfer(1'b0, 1'b1, 15'd7, 8'hFF, rd, t_cpu);
      check("R6 zero mask unchanged", mem[7], 32'h12345678);
      check("R7 zero mask still stores", wr_cnt - acc0, 1);

      // R4: bank offset on the memory address
      cpu_xfer(1'b1, 1'b1, 15'd0, 8'h0F, rd, t_cpu);
      cpu_xfer(1'b1, 1'b1, 15'd1, 8'h10, rd, t_cpu);
      mem[3] = 32'h0;
      mem[16 + 3] = 32'h0;
      cpu_xfer(1'b0, 1'b1, 15'd3, 8'hFF, rd, t_cpu);
      check("R4 banked address", {14'h0, last_addr}, 32'h2000C);
      check("R4 banked word written", mem[16 + 3], 32'hFFFFFFFF);
      check("R4 unbanked word untouched", mem[3], 32'h0);
      cpu_xfer(1'b1, 1'b1, 15'd1, 8'h00, rd, t_cpu);
      cpu_xfer(1'b0, 1'b0, 15'd5, 8'h00, rd, t_cpu);
      check("R4 plain address", {14'h0, last_addr}, 32'h00014);

      // R9: simultaneous requests to one word, mask 1
      cpu_xfer(1'b1, 1'b1, 15'd0, 8'h01, rd, t_cpu);
      mem[8] = 32'h0;
      fork
         begin logic [7:0] r1; dma_xfer(1'b1, 15'd8, 8'h0F, r1, t_dma); end
         begin logic [7:0] r2; cpu_xfer(1'b0, 1'b1, 15'd8, 8'hF0, r2, t_cpu); end
      join
      check("R9 dma served first (final word)", mem[8], 32'h00001111);
      check("R9 dma ready before cpu ready", {31'h0, t_dma < t_cpu}, 32'h1);

      summary();
      $finish;
   end

endmodule